// File: doc/BRIEF.md
# Transmit Phase-Align Buffer

This block carries transmit characters from the clock that captures them at the input register into the internal character-rate clock. It is a four-entry elastic store. The write pointer lives in the input clock domain and the read pointer lives in the character clock domain. Each pointer reaches the other side as Gray code through a two-flop synchronizer. The character-side logic watches for two faults. A write into a full store is dropped and counts as an overflow. A read from an empty store repeats the previous character and counts as an underflow. Either fault sets a sticky fault flag.

An active-low re-centre input is sampled on the character clock. It takes effect only from the second consecutive low sample onward. In the normal buffered mode it moves the read pointer to half the depth behind the synchronized write pointer and clears the fault. In this mode characters may be skipped or repeated. In the half-rate mode the same input only clears the fault and leaves the pointers alone. When both mode inputs are low, the store is bypassed: the output follows the input register directly, the re-centre input has no effect and the fault stays clear. A pulse marking the end of a complete word-sync sequence also clears the fault.

Top module: `tx_phase_align_buf`

## Requirements
- R1: While `rst_n` is low for an edge of both clocks, the block comes out with `fault` = 0, `rd_valid` = 0, `rd_data` = 0 and the store empty.
- R2: In buffered mode, characters written while the store is not full leave the read port in write order, each exactly once. Each one is marked by a single-cycle `rd_valid` high in the character clock cycle after the read is accepted.
- R3: A write while four characters are held is discarded. The store contents are unchanged, and `fault` goes high within a few character clock cycles.
- R4: `rd_en` on an empty store gives `rd_valid` = 0, leaves `rd_data` at its previous value, and sets `fault` at the same character clock edge.
- R5: A single low sample of `recenter_n`, followed by a high sample, moves no pointer and does not clear `fault`.
- R6: In full mode, `recenter_n` sampled low on a second or later consecutive character clock edge does three things. It sets the read pointer to the synchronized write pointer minus 2, leaving the two most recently written characters readable. It clears `fault`. Reads are not performed in that cycle.
- R7: Half-rate mode is `clk_sel` = 0 and `rate` = 1. In this mode a qualified re-centre (two or more consecutive low samples) clears `fault` and moves no pointer.
- R8: Bypass mode is `clk_sel` = 0 and `rate` = 0. In this mode `rd_data` and `rd_valid` are `wr_data` and `wr_en` registered on the input clock edge, `fault` is held at 0, and `recenter_n` is ignored.
- R9: `wsync_done` high at a character clock edge clears `fault`. A clear takes priority over an underflow or overflow in the same cycle.
- R10: Full mode is `clk_sel` = 1, whatever the value of `rate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input-register clock |
| rd_clk | input | 1 | Internal character-rate clock |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| clk_sel | input | 1 | Clock-select mode input |
| rate | input | 1 | Rate mode input |
| wr_en | input | 1 | Write strobe for wr_data (input clock) |
| wr_data | input | DATA_W | Character to store |
| rd_en | input | 1 | Read request (character clock) |
| recenter_n | input | 1 | Active-low re-centre / fault-clear request |
| wsync_done | input | 1 | Pulse marking completion of a word-sync sequence |
| rd_data | output | DATA_W | Character delivered on the character side |
| rd_valid | output | 1 | High for one cycle when rd_data holds a newly read character |
| fault | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench fills the store to exactly four characters and writes a fifth. A design that accepted that write would overwrite an unread character, and the scoreboard would see the oldest value replaced. It reads one character past empty. A design that cleared or advanced the output would show a changed `rd_data` or a spurious `rd_valid`. It gives `recenter_n` a single low sample, which a design with one-sample qualification would treat as a clear of the sticky fault. It re-centres with three characters pending and expects only the last two to come out. The same qualified re-centre in half-rate mode must keep all three, so a design that decoded the modes wrongly would drop a character in one case or the other. It raises `wsync_done` in the same cycle as an underflow, which catches a design that lets the set win. It checks in bypass that the output tracks the input one edge later and that the fault is forced low.

// File: rtl/pab_pkg.sv
// Package: shared mode type and decode for the transmit phase-align buffer.
// Assumes the two mode inputs are static during traffic.
package pab_pkg;

    typedef enum logic [1:0] {
        PAB_BYPASS = 2'd0,
        PAB_HALF   = 2'd1,
        PAB_FULL   = 2'd2
    } pab_mode_e;

    // Map the two mode pins onto an operating mode; clk_sel high always means full mode.
    function automatic pab_mode_e decode_mode(input logic sel, input logic rate);
        if (sel)
            return PAB_FULL;
        else if (rate)
            return PAB_HALF;
        else
            return PAB_BYPASS;
    endfunction

endpackage

// File: rtl/pab_sync.sv
// Module: pab_sync
// Two-flop synchronizer for a vector that changes at most one bit per
// source cycle (Gray pointer or toggle). Assumes synchronous active-low reset.
module pab_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two register stages in the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/pab_wr_ctrl.sv
// Module: pab_wr_ctrl
// Input-clock side: storage array, binary and Gray write pointers, full
// detection against the synchronized read pointer, overflow toggle, and the
// bypass holding register. Assumes rd_gray_s is already synchronized.
module pab_wr_ctrl #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_gray_s,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [PW-1:0]     wr_gray,
    output logic [PW-1:0]     wr_bin,
    output logic              wr_full,
    output logic              ovf_tgl,
    output logic [DATA_W-1:0] byp_data,
    output logic              byp_valid
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rd_bin_s;
    logic [PW-1:0]     fill;
    logic [PW-1:0]     wr_bin_nxt;
    logic              push;
    logic              drop;

    // Convert the synchronized Gray read pointer to binary.
    always_comb begin
        rd_bin_s[PW-1] = rd_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            rd_bin_s[i] = rd_bin_s[i+1] ^ rd_gray_s[i];
    end

    // Occupancy seen from the write side and the accept/drop decision.
    always_comb begin
        fill       = wr_bin - rd_bin_s;
        wr_full    = (fill >= PW'(DEPTH));
        push       = buf_en && wr_en && !wr_full;
        drop       = buf_en && wr_en && wr_full;
        wr_bin_nxt = push ? (wr_bin + PW'(1)) : wr_bin;
    end

    // Advance the write pointer in binary and Gray together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
        end
    end

    // Store accepted characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (push) begin
            mem[wr_bin[AW-1:0]] <= wr_data;
        end
    end

    // Flip the overflow toggle once per dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_tgl <= 1'b0;
        else if (drop)
            ovf_tgl <= ~ovf_tgl;
    end

    // Register the input character for the bypass path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_data  <= '0;
            byp_valid <= 1'b0;
        end else begin
            byp_valid <= wr_en;
            if (wr_en)
                byp_data <= wr_data;
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/pab_rd_ctrl.sv
// Module: pab_rd_ctrl
// Character-clock side: read pointer, empty detection, re-centre
// qualification, underflow detection and the sticky fault flag. Assumes
// wr_gray_s and ovf_s are already synchronized into this clock.
module pab_rd_ctrl
    import pab_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pab_mode_e         mode,
    input  logic              rd_en,
    input  logic              recenter_n,
    input  logic              wsync_done,
    input  logic [PW-1:0]     wr_gray_s,
    input  logic              ovf_s,
    input  logic [DATA_W-1:0] rd_word,
    output logic [AW-1:0]     rd_addr,
    output logic [PW-1:0]     rd_gray,
    output logic [PW-1:0]     rd_bin,
    output logic [PW-1:0]     wr_bin_s,
    output logic              rd_empty,
    output logic              recentre_q,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_valid,
    output logic              fault
);

    logic              lo_seen;
    logic              ovf_prev;
    logic              ovf_evt;
    logic              realign;
    logic              do_read;
    logic              underflow;
    logic [PW-1:0]     rd_bin_nxt;

    // Convert the synchronized Gray write pointer to binary.
    always_comb begin
        wr_bin_s[PW-1] = wr_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
    end

    // Decode qualified re-centre, reads, underflow and the next pointer.
    always_comb begin
        rd_empty   = (rd_bin == wr_bin_s);
        recentre_q = !recenter_n && lo_seen && (mode != PAB_BYPASS);
        realign    = recentre_q && (mode == PAB_FULL);
        do_read    = (mode != PAB_BYPASS) && !realign && rd_en && !rd_empty;
        underflow  = (mode != PAB_BYPASS) && !realign && rd_en && rd_empty;
        ovf_evt    = ovf_s ^ ovf_prev;
        if (realign)
            rd_bin_nxt = wr_bin_s - PW'(HALF);
        else if (do_read)
            rd_bin_nxt = rd_bin + PW'(1);
        else
            rd_bin_nxt = rd_bin;
    end

    // Remember whether the previous sample of the re-centre input was low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_seen <= 1'b0;
        else
            lo_seen <= !recenter_n;
    end

    // Track the synchronized overflow toggle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_prev <= 1'b0;
        else
            ovf_prev <= ovf_s;
    end

    // Update the read pointer in binary and Gray together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
        end
    end

    // Deliver a character on an accepted read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_data  <= '0;
            fifo_valid <= 1'b0;
        end else begin
            fifo_valid <= do_read;
            if (do_read)
                fifo_data <= rd_word;
        end
    end

    // Sticky fault: clears win over new events; forced low in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else if (mode == PAB_BYPASS)
            fault <= 1'b0;
        else if (recentre_q || wsync_done)
            fault <= 1'b0;
        else if (underflow || ovf_evt)
            fault <= 1'b1;
    end

    assign rd_addr = rd_bin[AW-1:0];

endmodule

// File: rtl/tx_phase_align_buf.sv
// Module: tx_phase_align_buf
// Top of the transmit phase-align buffer: decodes the mode, joins the write
// and read sides through Gray-pointer synchronizers, and selects the bypass
// path when the store is not in use. Assumes rst_n is held low across at
// least two edges of each clock.
module tx_phase_align_buf
    import pab_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic              rate,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              recenter_n,
    input  logic              wsync_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fault
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    pab_mode_e         mode;
    logic              buf_en;
    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     wr_gray_s;
    logic [PW-1:0]     wr_ptr_bin;
    logic [PW-1:0]     wr_bin_s;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     rd_gray_s;
    logic [PW-1:0]     rd_ptr_bin;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic              wr_full;
    logic              ovf_tgl;
    logic              ovf_s;
    logic [DATA_W-1:0] byp_data;
    logic              byp_valid;
    logic [DATA_W-1:0] fifo_data;
    logic              fifo_valid;
    logic              rd_empty;
    logic              recentre_q;

    // Mode decode shared by both sides.
    always_comb begin
        mode   = decode_mode(clk_sel, rate);
        buf_en = (mode != PAB_BYPASS);
    end

    pab_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .buf_en    (buf_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_gray_s (rd_gray_s),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .wr_gray   (wr_gray),
        .wr_bin    (wr_ptr_bin),
        .wr_full   (wr_full),
        .ovf_tgl   (ovf_tgl),
        .byp_data  (byp_data),
        .byp_valid (byp_valid)
    );

    pab_sync #(.W(PW)) u_sync_wptr (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    pab_sync #(.W(PW)) u_sync_rptr (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    pab_sync #(.W(1)) u_sync_ovf (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (ovf_tgl),
        .q     (ovf_s)
    );

    pab_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .rd_en      (rd_en),
        .recenter_n (recenter_n),
        .wsync_done (wsync_done),
        .wr_gray_s  (wr_gray_s),
        .ovf_s      (ovf_s),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .rd_gray    (rd_gray),
        .rd_bin     (rd_ptr_bin),
        .wr_bin_s   (wr_bin_s),
        .rd_empty   (rd_empty),
        .recentre_q (recentre_q),
        .fifo_data  (fifo_data),
        .fifo_valid (fifo_valid),
        .fault      (fault)
    );

    // Output select between the buffered and bypass paths.
    always_comb begin
        if (buf_en) begin
            rd_data  = fifo_data;
            rd_valid = fifo_valid;
        end else begin
            rd_data  = byp_data;
            rd_valid = byp_valid;
        end
    end

endmodule

// File: rtl/pab_chk.sv
// Module: pab_chk
// Property checker bound into tx_phase_align_buf. It observes the ports and
// the signals passed between the write side, read side and synchronizers.
module pab_chk
    import pab_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  pab_mode_e         mode,
    input  logic              wr_en,
    input  logic              wr_full,
    input  logic [PW-1:0]     wr_ptr_bin,
    input  logic              rd_en,
    input  logic              wsync_done,
    input  logic              recenter_n,
    input  logic              recentre_q,
    input  logic              rd_empty,
    input  logic [PW-1:0]     rd_ptr_bin,
    input  logic [PW-1:0]     wr_bin_s,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_valid,
    input  logic              fault
);

    // R3
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && wr_full && mode != PAB_BYPASS) |=> $stable(wr_ptr_bin));

    // R4
    underflow_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && rd_empty && !recentre_q && !wsync_done && mode != PAB_BYPASS)
        |=> ($stable(fifo_data) && !fifo_valid && fault));

    // R5
    single_low_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!recenter_n && $past(recenter_n) && fault && !wsync_done && mode != PAB_BYPASS)
        |=> fault);

    // R6
    recentre_ptr_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (recentre_q && mode == PAB_FULL) |=> (rd_ptr_bin == $past(wr_bin_s - PW'(HALF))));

    // R8
    bypass_no_fault_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (mode == PAB_BYPASS) |=> !fault);

    // R9
    wsync_clear_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (wsync_done && mode != PAB_BYPASS) |=> !fault);

endmodule

bind tx_phase_align_buf pab_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .wr_en      (wr_en),
    .wr_full    (wr_full),
    .wr_ptr_bin (wr_ptr_bin),
    .rd_en      (rd_en),
    .wsync_done (wsync_done),
    .recenter_n (recenter_n),
    .recentre_q (recentre_q),
    .rd_empty   (rd_empty),
    .rd_ptr_bin (rd_ptr_bin),
    .wr_bin_s   (wr_bin_s),
    .fifo_data  (fifo_data),
    .fifo_valid (fifo_valid),
    .fault      (fault)
);

// File: tb/tx_phase_align_buf_tb.sv
module tx_phase_align_buf_tb;

    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DATA_W    = 10;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_sel = 1'b1;
    logic              rate = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              recenter_n = 1'b1;
    logic              wsync_done = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              fault;

    int                vectors = 0;
    int                fails = 0;
    logic [DATA_W-1:0] sb[$];
    bit                mon_en = 1'b1;
    string             mon_tag = "R2";

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    tx_phase_align_buf #(.DATA_W(DATA_W), .DEPTH(4)) u_dut (
        .wr_clk     (wr_clk),
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel),
        .rate       (rate),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .recenter_n (recenter_n),
        .wsync_done (wsync_done),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .fault      (fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one write; optionally queue it as an expected output.
    task automatic wr_char(input logic [DATA_W-1:0] v, input bit expect_out);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        if (expect_out) sb.push_back(v);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_char();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic recentre_low(input int n);
        @(negedge rd_clk);
        recenter_n = 1'b0;
        repeat (n) @(negedge rd_clk);
        recenter_n = 1'b1;
    endtask

    // Monitor: pop and compare every delivered character.
    always @(negedge rd_clk) begin
        if (mon_en && rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                vectors++;
                fails++;
                $display("FAIL %s: actual %0h expected <none>", mon_tag, rd_data);
            end else begin
                chk(mon_tag, {22'd0, rd_data}, {22'd0, sb.pop_front()});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge wr_clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] held;
        // R1: reset state
        rd_wait(5);
        rst_n = 1'b1;
        rd_wait(1);
        chk("R1", {31'd0, fault}, 0);
        chk("R1", {31'd0, rd_valid}, 0);
        chk("R1", {22'd0, rd_data}, 0);

        // R2: three bursts of distinct patterns, full mode
        wr_char(10'h155, 1); wr_char(10'h2AA, 1); wr_char(10'h0F0, 1);
        rd_wait(5);
        repeat (3) rd_char();
        wr_char(10'h001, 1); wr_char(10'h3FF, 1); wr_char(10'h200, 1);
        rd_wait(5);
        repeat (3) rd_char();
        wr_char(10'h07C, 1); wr_char(10'h383, 1);
        rd_wait(5);
        rd_char();
        wr_char(10'h111, 1);
        rd_wait(5);
        repeat (2) rd_char();
        rd_wait(1);
        chk("R2", sb.size(), 0);
        chk("R2", {31'd0, fault}, 0);

        // R3: fifth write into a full store is dropped
        mon_tag = "R3";
        wr_char(10'h011, 1); wr_char(10'h022, 1); wr_char(10'h033, 1); wr_char(10'h044, 1);
        wr_char(10'h3EE, 0);
        rd_wait(6);
        chk("R3", {31'd0, fault}, 1);
        repeat (4) rd_char();
        rd_wait(1);
        chk("R3", sb.size(), 0);

        // R4: read of empty repeats the last character
        held = rd_data;
        rd_char();
        chk("R4", {31'd0, rd_valid}, 0);
        chk("R4", {22'd0, rd_data}, {22'd0, held});
        chk("R4", {31'd0, fault}, 1);

        // R9: word-sync clears; clear wins over a same-cycle underflow
        @(negedge rd_clk); wsync_done = 1'b1;
        @(negedge rd_clk); wsync_done = 1'b0;
        chk("R9", {31'd0, fault}, 0);
        rd_char();
        chk("R9", {31'd0, fault}, 1);
        @(negedge rd_clk); wsync_done = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk); wsync_done = 1'b0; rd_en = 1'b0;
        chk("R9", {31'd0, fault}, 0);

        // R5: a single low sample neither clears nor moves anything
        rd_char();
        recentre_low(1);
        rd_wait(2);
        chk("R5", {31'd0, fault}, 1);
        rd_char();
        chk("R5", {31'd0, rd_valid}, 0);

        // R6 / R10: full mode with rate high; re-centre keeps the last two
        mon_tag = "R6";
        @(negedge rd_clk); rate = 1'b1;
        wr_char(10'h0A1, 0); wr_char(10'h0B2, 0); wr_char(10'h0C3, 0);
        rd_wait(5);
        recentre_low(3);
        rd_wait(1);
        chk("R6", {31'd0, fault}, 0);
        sb.delete();
        sb.push_back(10'h0B2);
        sb.push_back(10'h0C3);
        repeat (2) rd_char();
        rd_wait(1);
        chk("R10", sb.size(), 0);

        // R7: half-rate mode, re-centre clears fault only
        mon_tag = "R7";
        @(negedge rd_clk); clk_sel = 1'b0; rate = 1'b1;
        rd_char();
        chk("R7", {31'd0, fault}, 1);
        wr_char(10'h1D4, 1); wr_char(10'h2E5, 1); wr_char(10'h3F6, 1);
        rd_wait(5);
        recentre_low(3);
        rd_wait(1);
        chk("R7", {31'd0, fault}, 0);
        repeat (3) rd_char();
        rd_wait(1);
        chk("R7", sb.size(), 0);

        // R8: bypass mode
        rd_char();
        chk("R8", {31'd0, fault}, 1);
        mon_en = 1'b0;
        @(negedge rd_clk); rate = 1'b0;
        rd_wait(1);
        chk("R8", {31'd0, fault}, 0);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = 10'h2C9;
        @(negedge wr_clk);
        chk("R8", {22'd0, rd_data}, 10'h2C9);
        chk("R8", {31'd0, rd_valid}, 1);
        wr_data = 10'h136;
        @(negedge wr_clk);
        chk("R8", {22'd0, rd_data}, 10'h136);
        wr_en = 1'b0;
        @(negedge wr_clk);
        chk("R8", {31'd0, rd_valid}, 0);
        chk("R8", {22'd0, rd_data}, 10'h136);
        recentre_low(3);
        rd_wait(1);
        chk("R8", {31'd0, fault}, 0);
        chk("R8", {22'd0, rd_data}, 10'h136);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule